// File: doc/BRIEF.md
# Write Drain Mode Controller

This block tells a memory channel scheduler when to stop favouring reads and drain its pending writes, and when to go back. It keeps its own count of the write address queue's occupancy, driven by enqueue and dequeue pulses. It compares that count against a pair of programmable thresholds with hysteresis. While a read is waiting, a second pair of thresholds applies instead, so a pending read can set a different tolerance for the drain.

Two further hints go to the scheduler. The first raises the priority of underfilled (partial) writes when their count passes a threshold. The second blocks medium-low priority reads from overtaking pending writes once the queue holds more than a set number of entries. All six thresholds are packed into one 32-bit configuration word, which software writes through a simple write port and can read back.

Top module: `wdrain_ctrl`

## Requirements
- R1: When reset is asserted, the mode flag is 0, the occupancy count is 0 and the configuration word reads 0x0DFFFED6. Those are the field values 22 (bits 4:0), 22 (bits 9:5), 31 (bits 14:10), 31 (bits 19:15), 31 (bits 24:20) and 6 (bits 29:25).
- R2: Bits 31:30 of the configuration word always read 0. Writes to them are ignored.
- R3: A configuration write with `cfg_we_i` high at a clock edge appears on `cfg_rdata_o` and takes effect in all comparisons from that edge on. No other event changes the word.
- R4: The occupancy count saturates at 0 and at DEPTH (32). An enqueue and a dequeue in the same cycle leave it unchanged. The count changes on the clock edge that samples the pulse.
- R5: With `rd_pend_i` low and the mode flag clear, the flag sets at the next edge when the count is strictly greater than bits 9:5.
- R6: With `rd_pend_i` low and the mode flag set, the flag clears at the next edge when the count is strictly less than bits 4:0.
- R7: With `rd_pend_i` high, entry uses bits 14:10 (strictly greater) and exit uses bits 19:15 (strictly less).
- R8: Otherwise the mode flag holds its value. It is a register and moves only on a clock edge, one edge after the count it reacts to.
- R9: `pw_boost_o` is high when `ufill_cnt_i` is strictly greater than bits 24:20. It is always low while that field is 31.
- R10: `rd_block_o` is high exactly when the current count is strictly greater than bits 29:25.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_wdata_i | input | 32 | Configuration write data |
| cfg_rdata_o | output | 32 | Configuration word readback |
| wq_push_i | input | 1 | Write queue enqueue pulse |
| wq_pop_i | input | 1 | Write queue dequeue pulse |
| rd_pend_i | input | 1 | A read is waiting |
| ufill_cnt_i | input | 6 | Number of underfill writes pending |
| wmaj_o | output | 1 | Write-major (drain) mode flag |
| pw_boost_o | output | 1 | Priority boost for partial writes |
| rd_block_o | output | 1 | Block medium-low priority reads |

## Verification
A wrong occupancy count first shows on `rd_block_o` in the same cycle, whenever the count crosses the block threshold. It shows on `wmaj_o` one edge later. Saturation faults appear only when the queue is pushed past full or popped past empty and then walked back across a threshold. A wrong mode register or a wrong threshold selection shows on `wmaj_o` at the edge after the count crosses the selected threshold. The bench therefore runs the count up and down across every threshold, both with and without a pending read. A corrupted configuration field shows at once on `cfg_rdata_o`.

// File: rtl/wdrain_pkg.sv
package wdrain_pkg;
  localparam int CFG_W = 32;
  localparam int THR_W = 5;

  typedef struct packed {
    logic [1:0]       rsv;
    logic [THR_W-1:0] blk_thr;  // read block threshold
    logic [THR_W-1:0] pw_thr;   // partial write boost threshold
    logic [THR_W-1:0] rx_thr;   // exit, read pending
    logic [THR_W-1:0] rn_thr;   // entry, read pending
    logic [THR_W-1:0] wn_thr;   // entry, no read
    logic [THR_W-1:0] wx_thr;   // exit, no read
  } cfg_t;

  localparam logic [THR_W-1:0] THR_MAX = '1;

  localparam cfg_t CFG_RST = '{
    rsv:     2'd0,
    blk_thr: 5'd6,
    pw_thr:  5'd31,
    rx_thr:  5'd31,
    rn_thr:  5'd31,
    wn_thr:  5'd22,
    wx_thr:  5'd22
  };

  localparam logic [CFG_W-1:0] CFG_WMASK = {2'b00, {(CFG_W-2){1'b1}}};
endpackage

// File: rtl/wdrain_cfg_reg.sv
module wdrain_cfg_reg
  import wdrain_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [CFG_W-1:0] wdata_i,
  output cfg_t             cfg_o
);
  cfg_t cfg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   cfg_q <= CFG_RST;
    else if (we_i) cfg_q <= cfg_t'(wdata_i & CFG_WMASK);
  end

  assign cfg_o = cfg_q;

  p_cfg_stable_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> $stable(cfg_q));
endmodule

// File: rtl/wdrain_occ_cnt.sv
module wdrain_occ_cnt #(
  parameter int DEPTH = 32,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  logic             pop_i,
  output logic [CNT_W-1:0] cnt_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(DEPTH);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic inc, dec;

  assign inc = push_i & ~pop_i & (cnt_q != CNT_MAX);
  assign dec = pop_i & ~push_i & (cnt_q != '0);

  always_comb begin
    cnt_d = cnt_q;
    if (inc)      cnt_d = cnt_q + 1'b1;
    else if (dec) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;

  p_cnt_bound_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_MAX);
  p_cnt_both_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && pop_i) |=> $stable(cnt_q));
endmodule

// File: rtl/wdrain_mode_fsm.sv
module wdrain_mode_fsm
  import wdrain_pkg::*;
#(
  parameter int CNT_W = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             rd_pend_i,
  input  cfg_t             cfg_i,
  output logic             wmaj_o
);
  logic [CNT_W-1:0] ent_thr, ext_thr;
  logic mode_q, go_in, go_out;

  // read presence picks the threshold pair
  assign ent_thr = rd_pend_i ? CNT_W'(cfg_i.rn_thr) : CNT_W'(cfg_i.wn_thr);
  assign ext_thr = rd_pend_i ? CNT_W'(cfg_i.rx_thr) : CNT_W'(cfg_i.wx_thr);

  assign go_in  = ~mode_q & (cnt_i > ent_thr);
  assign go_out =  mode_q & (cnt_i < ext_thr);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     mode_q <= 1'b0;
    else if (go_in)  mode_q <= 1'b1;
    else if (go_out) mode_q <= 1'b0;
  end

  assign wmaj_o = mode_q;

  p_enter_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rd_pend_i && !wmaj_o && cnt_i > CNT_W'(cfg_i.wn_thr)) |=> wmaj_o);
  p_exit_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rd_pend_i && wmaj_o && cnt_i < CNT_W'(cfg_i.wx_thr)) |=> !wmaj_o);
  p_enter_rd_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_pend_i && !wmaj_o && cnt_i > CNT_W'(cfg_i.rn_thr)) |=> wmaj_o);
  p_exit_rd_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_pend_i && wmaj_o && cnt_i < CNT_W'(cfg_i.rx_thr)) |=> !wmaj_o);
  p_hold_off_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wmaj_o && !rd_pend_i && cnt_i <= CNT_W'(cfg_i.wn_thr)) |=> !wmaj_o);
endmodule

// File: rtl/wdrain_prio.sv
module wdrain_prio
  import wdrain_pkg::*;
#(
  parameter int CNT_W = 6,
  parameter int UF_W  = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [UF_W-1:0]  ufill_i,
  input  cfg_t             cfg_i,
  output logic             boost_o,
  output logic             block_o
);
  logic pw_en;

  assign pw_en   = (cfg_i.pw_thr != THR_MAX);  // all ones disables the boost
  assign boost_o = pw_en & (ufill_i > UF_W'(cfg_i.pw_thr));
  assign block_o = cnt_i > CNT_W'(cfg_i.blk_thr);

  p_boost_off_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_i.pw_thr == THR_MAX) |-> !boost_o);
  p_block_zero_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_i == '0) |-> !block_o);
endmodule

// File: rtl/wdrain_ctrl.sv
module wdrain_ctrl
  import wdrain_pkg::*;
#(
  parameter int DEPTH = 32,
  parameter int UF_W  = 6,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cfg_we_i,
  input  logic [CFG_W-1:0] cfg_wdata_i,
  output logic [CFG_W-1:0] cfg_rdata_o,
  input  logic             wq_push_i,
  input  logic             wq_pop_i,
  input  logic             rd_pend_i,
  input  logic [UF_W-1:0]  ufill_cnt_i,
  output logic             wmaj_o,
  output logic             pw_boost_o,
  output logic             rd_block_o
);
  cfg_t             cfg;
  logic [CNT_W-1:0] occ;

  wdrain_cfg_reg u_cfg (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (cfg_we_i),
    .wdata_i (cfg_wdata_i),
    .cfg_o   (cfg)
  );

  wdrain_occ_cnt #(.DEPTH(DEPTH)) u_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .push_i (wq_push_i),
    .pop_i  (wq_pop_i),
    .cnt_o  (occ)
  );

  wdrain_mode_fsm #(.CNT_W(CNT_W)) u_mode (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .cnt_i     (occ),
    .rd_pend_i (rd_pend_i),
    .cfg_i     (cfg),
    .wmaj_o    (wmaj_o)
  );

  wdrain_prio #(.CNT_W(CNT_W), .UF_W(UF_W)) u_prio (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .cnt_i   (occ),
    .ufill_i (ufill_cnt_i),
    .cfg_i   (cfg),
    .boost_o (pw_boost_o),
    .block_o (rd_block_o)
  );

  assign cfg_rdata_o = cfg;

  p_rsv_read_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_we_i |=> (cfg_rdata_o[31:30] == 2'b00));
endmodule

// File: tb/tb_wdrain_ctrl.sv
module tb_wdrain_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 32;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cfg_we = 1'b0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic        push = 1'b0, pop = 1'b0, rd = 1'b0;
  logic [5:0]  uf = '0;
  logic        wmaj, boost, block;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  wdrain_ctrl dut (
    .clk_i(clk), .rst_ni(rst_ni), .cfg_we_i(cfg_we), .cfg_wdata_i(cfg_wdata),
    .cfg_rdata_o(cfg_rdata), .wq_push_i(push), .wq_pop_i(pop), .rd_pend_i(rd),
    .ufill_cnt_i(uf), .wmaj_o(wmaj), .pw_boost_o(boost), .rd_block_o(block)
  );

  function automatic logic [31:0] mk(int blk, int pw, int rx, int rn, int wn, int wx);
    return (32'(blk) << 25) | (32'(pw) << 20) | (32'(rx) << 15) |
           (32'(rn) << 10) | (32'(wn) << 5) | 32'(wx);
  endfunction

  // reference model
  int          m_cnt;
  bit          m_mode;
  logic [31:0] m_cfg;

  function automatic int fld(logic [31:0] c, int lsb);
    return int'((c >> lsb) & 32'h1f);
  endfunction

  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      m_cnt = 0; m_mode = 0; m_cfg = mk(6, 31, 31, 31, 22, 22);
    end else begin
      int ent, ext;
      ent = rd ? fld(m_cfg, 10) : fld(m_cfg, 5);
      ext = rd ? fld(m_cfg, 15) : fld(m_cfg, 0);
      if (!m_mode && m_cnt > ent)     m_mode = 1;
      else if (m_mode && m_cnt < ext) m_mode = 0;
      if (push && !pop && m_cnt < DEPTH) m_cnt++;
      else if (pop && !push && m_cnt > 0) m_cnt--;
      if (cfg_we) m_cfg = cfg_wdata & 32'h3fff_ffff;
    end
  end

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_ni && !done) begin
      bit e_boost, e_block;
      e_boost = (int'(uf) > fld(m_cfg, 20)) && (fld(m_cfg, 20) != 31);
      e_block = m_cnt > fld(m_cfg, 25);
      chk(wmaj == m_mode, "R5 R6 R7 R8 mode", 32'(wmaj), 32'(m_mode));
      chk(boost == e_boost, "R9 boost", 32'(boost), 32'(e_boost));
      chk(block == e_block, "R10 R4 block", 32'(block), 32'(e_block));
      chk(cfg_rdata == m_cfg, "R2 R3 cfg", cfg_rdata, m_cfg);
    end
  end

  task automatic step(bit pu, bit po, bit r, int u);
    @(negedge clk); #1;
    push = pu; pop = po; rd = r; uf = 6'(u); cfg_we = 0;
  endtask

  task automatic wr_cfg(logic [31:0] v);
    @(negedge clk); #1;
    push = 0; pop = 0; cfg_we = 1; cfg_wdata = v;
    @(negedge clk); #1;
    cfg_we = 0;
  endtask

  task automatic pushes(int n, bit r);
    for (int i = 0; i < n; i++) step(1, 0, r, 0);
    step(0, 0, r, 0);
    step(0, 0, r, 0);
    @(negedge clk);
  endtask

  task automatic pops(int n, bit r);
    for (int i = 0; i < n; i++) step(0, 1, r, 0);
    step(0, 0, r, 0);
    step(0, 0, r, 0);
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(wmaj == 0, "R1 reset mode", 32'(wmaj), 0);
    chk(cfg_rdata == 32'h0DFF_FED6, "R1 reset cfg", cfg_rdata, 32'h0DFF_FED6);
    chk(block == 0, "R1 reset count", 32'(block), 0);
    #1 rst_ni = 1;

    pushes(22, 0);
    chk(wmaj == 0, "R5 at 22 no entry", 32'(wmaj), 0);
    pushes(1, 0);
    chk(wmaj == 1, "R5 at 23 entry", 32'(wmaj), 1);
    pops(1, 0);
    chk(wmaj == 1, "R8 at 22 hold", 32'(wmaj), 1);
    pops(1, 0);
    chk(wmaj == 0, "R6 at 21 exit", 32'(wmaj), 0);

    wr_cfg(mk(6, 31, 5, 10, 22, 22));
    @(negedge clk);
    chk(cfg_rdata == mk(6, 31, 5, 10, 22, 22), "R3 write visible", cfg_rdata, mk(6, 31, 5, 10, 22, 22));
    pushes(0, 1);
    chk(wmaj == 1, "R7 read entry at 21", 32'(wmaj), 1);
    pops(16, 1);
    chk(wmaj == 1, "R8 read hold at 5", 32'(wmaj), 1);
    pops(1, 1);
    chk(wmaj == 0, "R7 read exit at 4", 32'(wmaj), 0);

    wr_cfg(32'hFFFF_FFFF);
    @(negedge clk);
    chk(cfg_rdata == 32'h3FFF_FFFF, "R2 reserved ignored", cfg_rdata, 32'h3FFF_FFFF);

    wr_cfg(mk(31, 31, 0, 31, 31, 0));
    step(0, 0, 0, 40); @(negedge clk);
    chk(boost == 0, "R9 disabled by 31", 32'(boost), 0);
    wr_cfg(mk(31, 10, 0, 31, 31, 0));
    step(0, 0, 0, 11); @(negedge clk);
    chk(boost == 1, "R9 above thr", 32'(boost), 1);
    step(0, 0, 0, 10); @(negedge clk);
    chk(boost == 0, "R9 equal thr", 32'(boost), 0);

    pops(10, 0);
    pushes(40, 0);
    chk(block == 1, "R10 full above 31", 32'(block), 1);
    step(1, 1, 0, 0); @(negedge clk);
    chk(block == 1, "R4 push+pop hold", 32'(block), 1);
    pops(1, 0);
    chk(block == 0, "R4 saturated at 32", 32'(block), 0);
    pops(40, 0);
    pushes(1, 0);
    wr_cfg(mk(0, 31, 0, 31, 31, 0));
    @(negedge clk);
    chk(block == 1, "R4 R10 empty floor", 32'(block), 1);

    for (int i = 0; i < 6000; i++) begin
      if ((i % 400) == 0) wr_cfg($urandom & 32'h3fff_ffff | (32'($urandom) << 30));
      step(($urandom % 3) != 0 && (i / 700) % 2 == 0 || ($urandom % 3) == 0,
           ($urandom % 2) == 0, ((i / 150) % 2) == 1, int'($urandom % 64));
    end
    @(negedge clk);
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule